// File: doc/BRIEF.md
# ADC Sample-Window and Conversion-Start Sequencer

This block sits in front of a successive-approximation converter and decides when the analog input is sampled and when conversion begins. It takes a software start bit and three hardware timer outputs, selects one of them as the trigger and optionally inverts it. It then produces a sample window in one of two ways. In timed mode, a rising trigger edge starts an internal down-counter, and the window lasts a power-of-two number of conversion-clock ticks. In follow mode, the window stays open for as long as the trigger stays high.

When the window closes, the block issues a single-cycle convert-start pulse. It holds busy high until the converter reports completion on a done strobe. The software start bit clears itself when that conversion completes. In timed mode, an optional repeat setting begins the next sample as soon as each conversion finishes, so conversions run back to back without further trigger edges. The conversion clock is represented by a clock-enable tick. Clock selection and division happen outside the block.

Top module: `adc_sample_sequencer`

## Requirements
- R1: After reset, sampleWin, convStart and busy are 0, and softStartBit is 0.
- R2: trigSel picks the trigger: 0 = softStartBit, 1 = timerA1, 2 = timerB0, 3 = timerB1. Activity on a source that is not selected starts no sample window.
- R3: When trigInvert is 1, the selected trigger is inverted before edge detection. A falling input edge then starts sampling, and a rising input edge does not.
- R4: In timed mode (pulseMode = 1), a rising trigger edge opens sampleWin for exactly 4 × 2^shtSel conversion ticks. shtSel is 3 bits wide.
- R5: In follow mode (pulseMode = 0), a rising trigger edge opens sampleWin. It stays open for as many cycles as the trigger stays high and closes when the trigger falls.
- R6: convStart is a one-cycle pulse. It is asserted in the first cycle after sampleWin closes.
- R7: busy is 1 from the first cycle of sampleWin until the cycle after convDone is seen, and 0 otherwise.
- R8: While convEnable is 0, no trigger edge starts a sample window.
- R9: softStartSet sets softStartBit, and softStartClr clears it. The bit also clears itself when convDone ends the conversion.
- R10: With multiConv = 1 in timed mode, each convDone starts the next timed window in the following cycle without a trigger edge. In follow mode, multiConv has no effect.
- R11: A trigger held high after a conversion does not start another window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convTick | input | 1 | Conversion-clock enable tick |
| convEnable | input | 1 | Allows new sampling to start |
| softStartSet | input | 1 | Sets the software start bit |
| softStartClr | input | 1 | Clears the software start bit |
| timerA1 | input | 1 | Hardware trigger source 1 |
| timerB0 | input | 1 | Hardware trigger source 2 |
| timerB1 | input | 1 | Hardware trigger source 3 |
| trigSel | input | 2 | Trigger source select |
| trigInvert | input | 1 | Invert the selected trigger |
| pulseMode | input | 1 | 1 = timed window, 0 = follow trigger |
| multiConv | input | 1 | Back-to-back repeat in timed mode |
| shtSel | input | 3 | Sample length exponent |
| convDone | input | 1 | Conversion complete strobe |
| sampleWin | output | 1 | Sample window |
| convStart | output | 1 | Start-conversion pulse |
| busy | output | 1 | Sampling or converting |
| softStartBit | output | 1 | Software start bit state |

## Verification
Timed windows are exercised with shtSel values of 0, 3 and 7. This confirms that the exponent scales the count and that no length is cut short by one. Follow-mode windows of different hold times check that the window tracks the trigger rather than the timer. Each source is selected in turn while the other sources toggle, and each source is also tried inverted. These patterns separate a wrong mux code or a wrong edge polarity from a correct start. Repeat-mode runs, trigger pulses sent while conversion is disabled, and a trigger held high after a conversion check that extra windows appear only in the cases where they are required.

// File: rtl/samp_seq_pkg.sv
package samp_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TIMED = 2'd1,
    ST_LEVEL = 2'd2,
    ST_CONV  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadTimer;
    logic goConvert;
    logic clrSoftStart;
  } ctrlStrobe_t;
endpackage

// File: rtl/samp_seq_datapath.sv
module samp_seq_datapath
  import samp_seq_pkg::*;
#(
  parameter int SRC_COUNT = 4,
  parameter int SEL_W     = 2,
  parameter int SHT_W     = 3,
  parameter int BASE_LOG2 = 2,
  parameter int CNT_W     = BASE_LOG2 + (1 << SHT_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 convTick,
  input  logic                 softSet,
  input  logic                 softClr,
  input  logic [SRC_COUNT-2:0] hwTrig,
  input  logic [SEL_W-1:0]     trigSel,
  input  logic                 trigInvert,
  input  logic [SHT_W-1:0]     shtSel,
  input  ctrlStrobe_t          strobe,
  output logic                 softBit,
  output logic                 trigLevel,
  output logic                 trigRise,
  output logic                 timerExpire,
  output logic [CNT_W-1:0]     timerCount
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam int               MIN_LEN = 1 << BASE_LOG2;

  logic [SRC_COUNT-1:0] srcVec;
  logic                 trigPrev;
  logic [CNT_W-1:0]     loadVal;

  assign srcVec[0] = softBit;
  for (genvar i = 1; i < SRC_COUNT; i++) begin : g_src
    assign srcVec[i] = hwTrig[i-1];
  end

  assign trigLevel = srcVec[trigSel] ^ trigInvert;
  assign trigRise  = trigLevel & ~trigPrev;
  assign loadVal   = ONE << (BASE_LOG2 + int'(shtSel));
  assign timerExpire = convTick && (timerCount == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigPrev <= 1'b0;
    end else begin
      trigPrev <= trigLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      softBit <= 1'b0;
    end else if (softSet) begin
      softBit <= 1'b1;
    end else if (softClr || strobe.clrSoftStart) begin
      softBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCount <= '0;
    end else if (strobe.loadTimer) begin
      timerCount <= loadVal;
    end else if (convTick && timerCount != '0) begin
      timerCount <= timerCount - ONE;
    end
  end

  AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTimer |=> (int'(timerCount) >= MIN_LEN && int'(timerCount) <= (MIN_LEN << ((1 << SHT_W) - 1)))); // R4

  AST_SOFT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrSoftStart && !softSet) |=> !softBit); // R9
endmodule

// File: rtl/samp_seq_control.sv
module samp_seq_control
  import samp_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        convEnable,
  input  logic        pulseMode,
  input  logic        multiConv,
  input  logic        convDone,
  input  logic        trigLevel,
  input  logic        trigRise,
  input  logic        timerExpire,
  output ctrlStrobe_t strobe,
  output logic        sampleWin,
  output logic        timedPhase,
  output logic        convStart,
  output logic        busy
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (convEnable && trigRise) begin
          if (pulseMode) begin
            stateNext        = ST_TIMED;
            strobe.loadTimer = 1'b1;
          end else begin
            stateNext = ST_LEVEL;
          end
        end
      end
      ST_TIMED: begin
        if (timerExpire) begin
          stateNext        = ST_CONV;
          strobe.goConvert = 1'b1;
        end
      end
      ST_LEVEL: begin
        if (!trigLevel) begin
          stateNext        = ST_CONV;
          strobe.goConvert = 1'b1;
        end
      end
      ST_CONV: begin
        if (convDone) begin
          strobe.clrSoftStart = 1'b1;
          if (pulseMode && multiConv && convEnable) begin
            stateNext        = ST_TIMED;
            strobe.loadTimer = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      convStart <= 1'b0;
    end else begin
      state     <= stateNext;
      convStart <= strobe.goConvert;
    end
  end

  assign sampleWin  = (state == ST_TIMED) || (state == ST_LEVEL);
  assign timedPhase = (state == ST_TIMED);
  assign busy       = (state != ST_IDLE);

  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !convEnable) |=> (state == ST_IDLE)); // R8

  AST_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R6

  AST_START_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !sampleWin); // R6
endmodule

// File: rtl/adc_sample_sequencer.sv
module adc_sample_sequencer
  import samp_seq_pkg::*;
#(
  parameter int SHT_W     = 3,
  parameter int BASE_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convTick,
  input  logic             convEnable,
  input  logic             softStartSet,
  input  logic             softStartClr,
  input  logic             timerA1,
  input  logic             timerB0,
  input  logic             timerB1,
  input  logic [1:0]       trigSel,
  input  logic             trigInvert,
  input  logic             pulseMode,
  input  logic             multiConv,
  input  logic [SHT_W-1:0] shtSel,
  input  logic             convDone,
  output logic             sampleWin,
  output logic             convStart,
  output logic             busy,
  output logic             softStartBit
);
  localparam int SRC_COUNT = 4;
  localparam int SEL_W     = $clog2(SRC_COUNT);
  localparam int CNT_W     = BASE_LOG2 + (1 << SHT_W);

  ctrlStrobe_t      strobe;
  logic             trigLevel;
  logic             trigRise;
  logic             timerExpire;
  logic             timedPhase;
  logic [CNT_W-1:0] timerCount;

  samp_seq_datapath #(
    .SRC_COUNT(SRC_COUNT),
    .SEL_W    (SEL_W),
    .SHT_W    (SHT_W),
    .BASE_LOG2(BASE_LOG2),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .convTick   (convTick),
    .softSet    (softStartSet),
    .softClr    (softStartClr),
    .hwTrig     ({timerB1, timerB0, timerA1}),
    .trigSel    (trigSel),
    .trigInvert (trigInvert),
    .shtSel     (shtSel),
    .strobe     (strobe),
    .softBit    (softStartBit),
    .trigLevel  (trigLevel),
    .trigRise   (trigRise),
    .timerExpire(timerExpire),
    .timerCount (timerCount)
  );

  samp_seq_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .convEnable (convEnable),
    .pulseMode  (pulseMode),
    .multiConv  (multiConv),
    .convDone   (convDone),
    .trigLevel  (trigLevel),
    .trigRise   (trigRise),
    .timerExpire(timerExpire),
    .strobe     (strobe),
    .sampleWin  (sampleWin),
    .timedPhase (timedPhase),
    .convStart  (convStart),
    .busy       (busy)
  );

  AST_WIN_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sampleWin |-> busy); // R7

  AST_TIMER_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    timedPhase |-> (timerCount != '0)); // R4

  AST_DONE_CLEARS_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sampleWin && convDone && !softStartSet) |=> !softStartBit); // R9
endmodule

// File: tb/adc_sample_sequencer_bench.sv
module adc_sample_sequencer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convTick = 1'b1;
  logic convEnable = 1'b0;
  logic softStartSet = 1'b0, softStartClr = 1'b0;
  logic timerA1 = 1'b0, timerB0 = 1'b0, timerB1 = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic trigInvert = 1'b0, pulseMode = 1'b1, multiConv = 1'b0;
  logic [2:0] shtSel = 3'd0;
  logic convDone = 1'b0;
  logic sampleWin, convStart, busy, softStartBit;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int expQ[$];
  int winLen = 0;
  logic prevWin = 1'b0;
  int doneWait = -1;
  logic doneAck = 1'b0;

  always #2 clk = ~clk;

  adc_sample_sequencer u_adc_sample_sequencer (
    .clk(clk), .rstN(rstN), .convTick(convTick), .convEnable(convEnable),
    .softStartSet(softStartSet), .softStartClr(softStartClr),
    .timerA1(timerA1), .timerB0(timerB0), .timerB1(timerB1),
    .trigSel(trigSel), .trigInvert(trigInvert), .pulseMode(pulseMode),
    .multiConv(multiConv), .shtSel(shtSel), .convDone(convDone),
    .sampleWin(sampleWin), .convStart(convStart), .busy(busy),
    .softStartBit(softStartBit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: measures each window and compares with the scoreboard queue.
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleWin) begin
        winLen++;
        if (!busy) check("R7 busy during window", busy, 1);
      end else if (prevWin) begin
        if (expQ.size() == 0) begin
          check("R2/R8/R11 unexpected window", winLen, 0);
        end else begin
          check("R4/R5 window length", winLen, expQ.pop_front());
        end
        check("R6 convStart after window", convStart, 1);
        winLen = 0;
      end
      prevWin = sampleWin;
    end
  end

  // Converter model: done strobe three cycles after each convStart.
  always @(negedge clk) begin
    if (doneAck) begin
      doneAck = 1'b0;
      if (!sampleWin) check("R7 busy drops after done", busy, 0);
    end
    if (convDone) begin
      convDone = 1'b0;
      doneAck = 1'b1;
    end else if (doneWait == 0) begin
      convDone = 1'b1;
      doneWait = -1;
    end else if (doneWait > 0) begin
      doneWait--;
    end
    if (convStart) doneWait = 2;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle();
    cyc(2);
    while (busy || convDone || doneWait >= 0) @(negedge clk);
    cyc(2);
  endtask

  task automatic pulseHw(input int which, input int hold);
    @(negedge clk);
    case (which)
      1: timerA1 = 1'b1;
      2: timerB0 = 1'b1;
      default: timerB1 = 1'b1;
    endcase
    cyc(hold);
    case (which)
      1: timerA1 = 1'b0;
      2: timerB0 = 1'b0;
      default: timerB1 = 1'b0;
    endcase
  endtask

  initial begin
    cyc(3);
    check("R1 reset sampleWin", sampleWin, 0);
    check("R1 reset convStart", convStart, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset softStartBit", softStartBit, 0);
    rstN = 1'b1;
    cyc(2);
    convEnable = 1'b1;

    // R2, R4: each hardware source in timed mode; others ignored
    for (int s = 1; s < 4; s++) begin
      trigSel = 2'(s);
      for (int o = 1; o < 4; o++) if (o != s) pulseHw(o, 3);
      cyc(3);
      check("R2 unselected source ignored", busy, 0);
      expQ.push_back(4);
      pulseHw(s, 2);
      waitIdle();
    end

    // R4: longer windows
    trigSel = 2'd1;
    shtSel = 3'd3; expQ.push_back(32); pulseHw(1, 2); waitIdle();
    shtSel = 3'd7; expQ.push_back(512); pulseHw(1, 2); waitIdle();
    shtSel = 3'd0;

    // R11: trigger held high after conversion
    expQ.push_back(4);
    @(negedge clk); timerA1 = 1'b1;
    waitIdle(); cyc(20);
    check("R11 held trigger no restart", busy, 0);
    timerA1 = 1'b0; cyc(2);

    // R9: software start in timed mode
    trigSel = 2'd0;
    expQ.push_back(4);
    @(negedge clk); softStartSet = 1'b1;
    @(negedge clk); softStartSet = 1'b0;
    check("R9 soft bit set", softStartBit, 1);
    while (!convStart) @(negedge clk);
    check("R9 soft bit held during conversion", softStartBit, 1);
    waitIdle();
    check("R9 soft bit self clears", softStartBit, 0);

    // R5: follow mode, hardware and software
    pulseMode = 1'b0;
    trigSel = 2'd2;
    expQ.push_back(7); pulseHw(2, 7); waitIdle();
    expQ.push_back(1); pulseHw(2, 1); waitIdle();
    trigSel = 2'd0;
    expQ.push_back(6);
    @(negedge clk); softStartSet = 1'b1;
    @(negedge clk); softStartSet = 1'b0;
    cyc(5);
    softStartClr = 1'b1;
    @(negedge clk); softStartClr = 1'b0;
    waitIdle();
    check("R9 soft bit cleared by write", softStartBit, 0);

    // R10: multiConv ignored in follow mode
    multiConv = 1'b1;
    trigSel = 2'd3;
    expQ.push_back(5); pulseHw(3, 5); waitIdle();
    check("R10 follow mode single conversion", expQ.size(), 0);

    // R3: inverted trigger, timed mode
    pulseMode = 1'b0; multiConv = 1'b0;
    convEnable = 1'b0;
    trigSel = 2'd1; trigInvert = 1'b1;
    pulseMode = 1'b1;
    cyc(3);
    convEnable = 1'b1;
    @(negedge clk); timerA1 = 1'b1;
    cyc(6);
    check("R3 inverted rising input no start", busy, 0);
    expQ.push_back(4);
    timerA1 = 1'b0;
    waitIdle();
    // R3: inverted, follow mode (window while input low)
    pulseMode = 1'b0;
    timerA1 = 1'b1; cyc(3);
    expQ.push_back(5);
    timerA1 = 1'b0; cyc(5); timerA1 = 1'b1;
    waitIdle();
    convEnable = 1'b0; trigInvert = 1'b0; timerA1 = 1'b0;
    pulseMode = 1'b1; cyc(3);

    // R8: disabled blocks starts
    pulseHw(1, 3); cyc(5);
    check("R8 disabled no start", busy, 0);
    convEnable = 1'b1; cyc(2);

    // R10: back-to-back in timed mode
    multiConv = 1'b1; shtSel = 3'd1;
    expQ.push_back(8); expQ.push_back(8); expQ.push_back(8);
    pulseHw(1, 2);
    while (!convStart) @(negedge clk);
    @(negedge clk);
    while (!sampleWin) @(negedge clk);
    while (!convStart) @(negedge clk);
    @(negedge clk);
    while (!sampleWin) @(negedge clk);
    multiConv = 1'b0;
    waitIdle();
    check("R10 three back-to-back windows", expQ.size(), 0);
    cyc(10);
    check("R10 stops when repeat cleared", busy, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule